// File: doc/BRIEF.md
# Elapsed-Time Real-Time Clock with Interval Timers

This peripheral keeps wall-clock time as a 48-bit count of 32768 Hz oscillator ticks. The oscillator reaches the block as a single-cycle clock enable, `tickEn`. The lowest 16 bits count 1/32768 s steps, so the upper 32 bits advance once every 2 seconds. Software sets the time by writing any of the three 16-bit time words. It reads the words back live, with no snapshot between the words.

Next to the time base sit three interrupt sources. The first is a 48-bit compare value that fires when the counter reaches it. The other two are periodic interval timers. Each timer has a 32-bit interval and a readable 32-bit down-count. Loading zero into a source disables it. All sources collect in a status register that software clears by writing ones. Any set status bit drives the single interrupt line.

All accesses are 16-bit. A write takes effect on the clock edge where `busSel` and `busWr` are both high. Read data is combinational from `busAddr` while `busSel` is high.

Top module: `rtc_elapse_timer`

## Requirements
- R1: After reset, every readable register reads 0 and `irqOut` is low.
- R2: Each cycle with `tickEn` high adds one to the 48-bit time. A carry out of the low word (address 2) goes into the middle word (address 1), and the middle word carries into the high word (address 0). With `tickEn` low and no time write, the time holds.
- R3: A time-word write replaces only the addressed word. In a cycle that writes a time word, the tick is dropped and the counter does not increment.
- R4: A read returns the live value of the addressed register. Address 15 reads 0. Reading has no side effect.
- R5: Status bit 0 sets on the tick that makes the time equal the 48-bit compare value (addresses 3, 4, 5, high to low). A compare value of zero never sets the bit, not even when the time wraps to zero.
- R6: Timer t (t = 0 or 1) has its interval at addresses 6+4t (high) and 7+4t (low), and its count at 8+4t (high) and 9+4t (low). With interval N not zero, the count steps down N, N-1, ..., 1. The tick that finds the count at 1 reloads N and sets status bit 1+t, so the bit sets once every N ticks.
- R7: A timer with interval zero holds its count at 0 and never sets its status bit.
- R8: Writing either interval word loads the count with the new full interval, which restarts the period.
- R9: Writing the status register (address 14) clears each bit written as 1 and leaves bits written as 0. `irqOut` is high exactly when some status bit is set.
- R10: When a source event and a clear of the same status bit fall in the same cycle, the bit ends set.
- R11: A cycle without both `busSel` and `busWr` high changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | One-cycle pulse per 32768 Hz oscillator tick |
| busSel | input | 1 | Register access select |
| busWr | input | 1 | Write when high, read when low |
| busAddr | input | 4 | 16-bit word address |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Live read data for the addressed register |
| irqOut | output | 1 | OR of all status bits |

## Verification
The embedded assertions check, on every cycle, several invariants. The time steps by exactly one on an undisturbed tick and holds otherwise. A compare hit leaves the counter equal to the compare value. A firing timer reloads its interval, and an interval write reloads the count. A zero interval implies a zero count. Cleared status bits drop unless an event arrives, and events always win over clears. Only the bench's scenarios can show the address map and the carry across word boundaries. They also cover the silence of a zero compare value across a 48-bit wrap, the period of each timer counted in ticks, and the separation between the two timers.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int REG_W       = 16;
  localparam int TIME_W      = 48;
  localparam int TIME_WORDS  = TIME_W / REG_W;
  localparam int TMR_W       = 32;
  localparam int NUM_TMR     = 2;
  localparam int NUM_SRC     = NUM_TMR + 1;
  localparam int SRC_CMP     = 0;
  // word address map: time words, compare words, then per-timer blocks
  localparam int ADDR_TIME   = 0;
  localparam int ADDR_CMP    = TIME_WORDS;
  localparam int ADDR_TMR    = 2 * TIME_WORDS;
  localparam int TMR_STRIDE  = 4;
  localparam int ADDR_STATUS = ADDR_TMR + TMR_STRIDE * NUM_TMR;
  localparam int ADDR_W      = $clog2(ADDR_STATUS + 1);

  // strobes from control to datapath; word bit 0 is the least significant word
  typedef struct packed {
    logic [TIME_WORDS-1:0] timeWr;
    logic [TIME_WORDS-1:0] cmpWr;
    logic [NUM_TMR-1:0]    perHiWr;
    logic [NUM_TMR-1:0]    perLoWr;
    logic                  statusWr;
    logic [REG_W-1:0]      wdata;
  } rtcStrobe_t;
endpackage

// File: rtl/rtc_interval_timer.sv
module rtc_interval_timer #(
  parameter int CNT_W = 32,
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             wrHi,
  input  logic             wrLo,
  input  logic [REG_W-1:0] wdata,
  output logic [CNT_W-1:0] intervalVal,
  output logic [CNT_W-1:0] countVal,
  output logic             fire
);
  localparam int HI_W = CNT_W - REG_W;

  logic             wrAny;
  logic [CNT_W-1:0] nextInterval;

  assign wrAny = wrHi | wrLo;

  always_comb begin
    nextInterval = intervalVal;
    if (wrHi) nextInterval[CNT_W-1:REG_W] = wdata[HI_W-1:0];
    if (wrLo) nextInterval[REG_W-1:0]     = wdata;
  end

  // terminal tick: count at one (or below) with a live interval
  assign fire = tickEn && !wrAny && (intervalVal != '0) && (countVal <= CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      intervalVal <= '0;
      countVal    <= '0;
    end else if (wrAny) begin
      intervalVal <= nextInterval;
      countVal    <= nextInterval;
    end else if (tickEn && (intervalVal != '0)) begin
      if (countVal <= CNT_W'(1)) countVal <= intervalVal;
      else                       countVal <= countVal - CNT_W'(1);
    end
  end

  // R7: a disabled timer rests at zero
  assert_zero_rest_R7: assert property (@(posedge clk) disable iff (!rstN)
    (intervalVal == '0) |-> (countVal == '0))
    else $error("R7 count nonzero with zero interval");

  // R6: a firing tick reloads the interval
  assert_reload_R6: assert property (@(posedge clk) disable iff (!rstN)
    fire |=> (countVal == $past(intervalVal)))
    else $error("R6 reload missing");

  // R8: interval write restarts the count
  assert_restart_R8: assert property (@(posedge clk) disable iff (!rstN)
    wrAny |=> (countVal == intervalVal))
    else $error("R8 restart missing");
endmodule

// File: rtl/rtc_datapath.sv
module rtc_datapath
  import rtc_pkg::*;
(
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             tickEn,
  input  rtcStrobe_t                       strobe,
  output logic [TIME_W-1:0]                timeCount,
  output logic [TIME_W-1:0]                cmpVal,
  output logic [NUM_TMR-1:0][TMR_W-1:0]    tmrInterval,
  output logic [NUM_TMR-1:0][TMR_W-1:0]    tmrCount,
  output logic [NUM_SRC-1:0]               events
);
  logic [TIME_W-1:0] timeNext;
  logic [TIME_W-1:0] cmpNext;
  logic              timeWrAny;
  logic              cmpHit;

  assign timeWrAny = |strobe.timeWr;

  always_comb begin
    timeNext = timeCount;
    if (timeWrAny) begin
      for (int w = 0; w < TIME_WORDS; w++)
        if (strobe.timeWr[w]) timeNext[w*REG_W +: REG_W] = strobe.wdata;
    end else if (tickEn) begin
      timeNext = timeCount + TIME_W'(1);
    end
  end

  always_comb begin
    cmpNext = cmpVal;
    for (int w = 0; w < TIME_WORDS; w++)
      if (strobe.cmpWr[w]) cmpNext[w*REG_W +: REG_W] = strobe.wdata;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      timeCount <= '0;
      cmpVal    <= '0;
    end else begin
      timeCount <= timeNext;
      cmpVal    <= cmpNext;
    end
  end

  // hit on the tick that brings the count onto a nonzero compare value
  assign cmpHit = tickEn && !timeWrAny && (cmpVal != '0) &&
                  ((timeCount + TIME_W'(1)) == cmpVal);
  assign events[SRC_CMP] = cmpHit;

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
    rtc_interval_timer #(.CNT_W(TMR_W), .REG_W(REG_W)) u_tmr (
      .clk        (clk),
      .rstN       (rstN),
      .tickEn     (tickEn),
      .wrHi       (strobe.perHiWr[t]),
      .wrLo       (strobe.perLoWr[t]),
      .wdata      (strobe.wdata),
      .intervalVal(tmrInterval[t]),
      .countVal   (tmrCount[t]),
      .fire       (events[1+t])
    );
  end

  // R2: an undisturbed tick steps the time by one
  assert_time_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && !timeWrAny) |=> (timeCount == $past(timeCount) + TIME_W'(1)))
    else $error("R2 time step wrong");

  // R3: no tick and no write keeps the time
  assert_time_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn && !timeWrAny) |=> $stable(timeCount))
    else $error("R3 time moved");

  // R5: a compare hit lands the time on the compare value
  assert_cmp_land_R5: assert property (@(posedge clk) disable iff (!rstN)
    cmpHit |=> (timeCount == $past(cmpVal)))
    else $error("R5 compare hit off target");
endmodule

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          busSel,
  input  logic                          busWr,
  input  logic [ADDR_W-1:0]             busAddr,
  input  logic [REG_W-1:0]              busWdata,
  input  logic [NUM_SRC-1:0]            events,
  input  logic [TIME_W-1:0]             timeCount,
  input  logic [TIME_W-1:0]             cmpVal,
  input  logic [NUM_TMR-1:0][TMR_W-1:0] tmrInterval,
  input  logic [NUM_TMR-1:0][TMR_W-1:0] tmrCount,
  output rtcStrobe_t                    strobe,
  output logic [REG_W-1:0]              busRdata,
  output logic                          irqOut
);
  logic               wrEn;
  logic [NUM_SRC-1:0] statusReg;
  logic [NUM_SRC-1:0] clearMask;

  assign wrEn = busSel && busWr;

  // write decode; address ADDR_TIME holds the most significant word
  always_comb begin
    strobe       = '0;
    strobe.wdata = busWdata;
    for (int w = 0; w < TIME_WORDS; w++) begin
      strobe.timeWr[TIME_WORDS-1-w] = wrEn && (busAddr == ADDR_W'(ADDR_TIME + w));
      strobe.cmpWr[TIME_WORDS-1-w]  = wrEn && (busAddr == ADDR_W'(ADDR_CMP + w));
    end
    for (int t = 0; t < NUM_TMR; t++) begin
      strobe.perHiWr[t] = wrEn && (busAddr == ADDR_W'(ADDR_TMR + TMR_STRIDE*t));
      strobe.perLoWr[t] = wrEn && (busAddr == ADDR_W'(ADDR_TMR + TMR_STRIDE*t + 1));
    end
    strobe.statusWr = wrEn && (busAddr == ADDR_W'(ADDR_STATUS));
  end

  // live read mux
  always_comb begin
    busRdata = '0;
    if (busSel) begin
      for (int w = 0; w < TIME_WORDS; w++) begin
        if (busAddr == ADDR_W'(ADDR_TIME + w))
          busRdata = timeCount[(TIME_WORDS-1-w)*REG_W +: REG_W];
        if (busAddr == ADDR_W'(ADDR_CMP + w))
          busRdata = cmpVal[(TIME_WORDS-1-w)*REG_W +: REG_W];
      end
      for (int t = 0; t < NUM_TMR; t++) begin
        if (busAddr == ADDR_W'(ADDR_TMR + TMR_STRIDE*t))     busRdata = tmrInterval[t][TMR_W-1:REG_W];
        if (busAddr == ADDR_W'(ADDR_TMR + TMR_STRIDE*t + 1)) busRdata = tmrInterval[t][REG_W-1:0];
        if (busAddr == ADDR_W'(ADDR_TMR + TMR_STRIDE*t + 2)) busRdata = tmrCount[t][TMR_W-1:REG_W];
        if (busAddr == ADDR_W'(ADDR_TMR + TMR_STRIDE*t + 3)) busRdata = tmrCount[t][REG_W-1:0];
      end
      if (busAddr == ADDR_W'(ADDR_STATUS))
        busRdata = REG_W'(statusReg);
    end
  end

  assign clearMask = strobe.statusWr ? busWdata[NUM_SRC-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) statusReg <= '0;
    else       statusReg <= (statusReg & ~clearMask) | events;
  end

  assign irqOut = |statusReg;

  // R9: bits written as one drop unless an event arrives
  assert_w1c_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.statusWr |=> ((statusReg & $past(busWdata[NUM_SRC-1:0] & ~events)) == '0))
    else $error("R9 clear ignored");

  // R10: an event always lands, clear or not
  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rstN)
    (events != '0) |=> ((statusReg & $past(events)) == $past(events)))
    else $error("R10 event lost");

  // R11: no write strobe without select and write
  assert_no_stray_R11: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |-> (strobe.timeWr == '0 && strobe.cmpWr == '0 && !strobe.statusWr))
    else $error("R11 stray strobe");
endmodule

// File: rtl/rtc_elapse_timer.sv
module rtc_elapse_timer
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [REG_W-1:0]  busWdata,
  output logic [REG_W-1:0]  busRdata,
  output logic              irqOut
);
  rtcStrobe_t                    strobe;
  logic [TIME_W-1:0]             timeCount;
  logic [TIME_W-1:0]             cmpVal;
  logic [NUM_TMR-1:0][TMR_W-1:0] tmrInterval;
  logic [NUM_TMR-1:0][TMR_W-1:0] tmrCount;
  logic [NUM_SRC-1:0]            events;

  rtc_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .busSel     (busSel),
    .busWr      (busWr),
    .busAddr    (busAddr),
    .busWdata   (busWdata),
    .events     (events),
    .timeCount  (timeCount),
    .cmpVal     (cmpVal),
    .tmrInterval(tmrInterval),
    .tmrCount   (tmrCount),
    .strobe     (strobe),
    .busRdata   (busRdata),
    .irqOut     (irqOut)
  );

  rtc_datapath u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .tickEn     (tickEn),
    .strobe     (strobe),
    .timeCount  (timeCount),
    .cmpVal     (cmpVal),
    .tmrInterval(tmrInterval),
    .tmrCount   (tmrCount),
    .events     (events)
  );
endmodule

// File: tb/rtc_elapse_timer_bench.sv
`timescale 1ns/100ps
module rtc_elapse_timer_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic        busSel = 1'b0;
  logic        busWr = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic        irqOut;
  logic        rdValid = 1'b0;

  int testsRun = 0;
  int testsFailed = 0;
  logic [47:0] mTime = '0;

  typedef struct {
    logic [3:0]  addr;
    logic [15:0] exp;
    bit          isIrq;
    string       tag;
  } item_t;
  item_t sbQ[$];

  always #2.5 clk = ~clk;

  rtc_elapse_timer u_rtc_elapse_timer (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut)
  );

  // monitor: pops expected items and compares mid-cycle
  always @(negedge clk) begin
    if (rdValid) begin
      item_t it;
      logic [15:0] act;
      if (sbQ.size() == 0) begin
        testsRun++; testsFailed++;
        $display("FAIL scoreboard empty: act %h exp none", busRdata);
      end else begin
        it = sbQ.pop_front();
        act = it.isIrq ? {15'd0, irqOut} : busRdata;
        testsRun++;
        if (act !== it.exp) begin
          testsFailed++;
          $display("FAIL %s addr %0d: act %h exp %h", it.tag, it.addr, act, it.exp);
        end
      end
    end
  end

  task automatic cycle(input logic tk, input logic s, input logic w,
                       input logic [3:0] a, input logic [15:0] d, input logic rv);
    @(posedge clk); #1;
    tickEn = tk; busSel = s; busWr = w; busAddr = a; busWdata = d; rdValid = rv;
  endtask

  task automatic modelWrite(input logic [3:0] a, input logic [15:0] d);
    if (a == 4'd0) mTime[47:32] = d;
    if (a == 4'd1) mTime[31:16] = d;
    if (a == 4'd2) mTime[15:0]  = d;
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    cycle(1'b0, 1'b1, 1'b1, a, d, 1'b0);
    modelWrite(a, d);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      cycle(1'b1, 1'b0, 1'b0, 4'd0, 16'd0, 1'b0);
      mTime = mTime + 48'd1;
    end
  endtask

  task automatic chk(input logic [3:0] a, input logic [15:0] e, input string tag);
    item_t it;
    it.addr = a; it.exp = e; it.isIrq = 1'b0; it.tag = tag;
    sbQ.push_back(it);
    cycle(1'b0, 1'b1, 1'b0, a, 16'd0, 1'b1);
  endtask

  task automatic chkIrq(input logic e, input string tag);
    item_t it;
    it.addr = 4'd0; it.exp = {15'd0, e}; it.isIrq = 1'b1; it.tag = tag;
    sbQ.push_back(it);
    cycle(1'b0, 1'b0, 1'b0, 4'd0, 16'd0, 1'b1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog: act hung exp finished");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    chk(4'd0, 16'h0, "R1 time hi");
    chk(4'd2, 16'h0, "R1 time lo");
    chk(4'd5, 16'h0, "R1 cmp lo");
    chk(4'd9, 16'h0, "R1 tmr0 count");
    chk(4'd14, 16'h0, "R1 status");
    chkIrq(1'b0, "R1 irq");

    // R2 counting and carry
    ticks(5);
    chk(4'd2, mTime[15:0], "R2 five ticks");
    wr(4'd0, 16'h0001); wr(4'd1, 16'h1234); wr(4'd2, 16'hFFFE);
    ticks(3);
    chk(4'd2, mTime[15:0], "R2 low wrap");
    chk(4'd1, mTime[31:16], "R2 carry mid");
    chk(4'd0, mTime[47:32], "R3 hi untouched");

    // R3 write in a tick cycle drops the tick
    cycle(1'b1, 1'b1, 1'b1, 4'd2, 16'h0100, 1'b0);
    modelWrite(4'd2, 16'h0100);
    chk(4'd2, 16'h0100, "R3 write beats tick");
    chk(4'd1, 16'h1235, "R3 other word kept");

    // R11 incomplete strobes change nothing
    cycle(1'b0, 1'b0, 1'b1, 4'd2, 16'h5555, 1'b0);
    cycle(1'b0, 1'b1, 1'b0, 4'd2, 16'h5555, 1'b0);
    chk(4'd2, 16'h0100, "R11 no write");

    // R4 live repeatable reads, unused address
    chk(4'd2, 16'h0100, "R4 repeat read");
    chk(4'd15, 16'h0, "R4 unused addr");

    // R5 compare
    wr(4'd0, 16'h0); wr(4'd1, 16'h0); wr(4'd2, 16'h0010);
    wr(4'd3, 16'h0); wr(4'd4, 16'h0); wr(4'd5, 16'h0014);
    chk(4'd5, 16'h0014, "R4 cmp readback");
    ticks(3);
    chk(4'd14, 16'h0, "R5 before hit");
    ticks(1);
    chk(4'd14, 16'h1, "R5 hit");
    chkIrq(1'b1, "R9 irq on");
    chk(4'd2, 16'h0014, "R5 time at cmp");

    // R9 write-one-to-clear
    wr(4'd14, 16'h0006);
    chk(4'd14, 16'h1, "R9 zero bits keep");
    wr(4'd14, 16'h0001);
    chk(4'd14, 16'h0, "R9 cleared");
    chkIrq(1'b0, "R9 irq off");

    // R5 zero compare never fires across wrap
    wr(4'd5, 16'h0);
    wr(4'd0, 16'hFFFF); wr(4'd1, 16'hFFFF); wr(4'd2, 16'hFFFE);
    ticks(2);
    chk(4'd2, 16'h0, "R2 48-bit wrap lo");
    chk(4'd0, 16'h0, "R2 48-bit wrap hi");
    chk(4'd14, 16'h0, "R5 zero cmp silent");

    // R6/R8 timer 0
    wr(4'd7, 16'd4);
    chk(4'd9, 16'd4, "R8 load count");
    ticks(3);
    chk(4'd9, 16'd1, "R6 count down");
    chk(4'd14, 16'h0, "R6 not yet");
    ticks(1);
    chk(4'd14, 16'h2, "R6 first fire");
    chk(4'd9, 16'd4, "R6 reload");
    wr(4'd14, 16'h2);
    ticks(4);
    chk(4'd14, 16'h2, "R6 second period");
    wr(4'd14, 16'h2);
    ticks(2);
    chk(4'd9, 16'd2, "R6 mid period");
    wr(4'd7, 16'd6);
    chk(4'd9, 16'd6, "R8 restart lo");
    wr(4'd6, 16'h0001);
    chk(4'd8, 16'h0001, "R8 restart hi count");
    chk(4'd9, 16'd6, "R8 restart lo count");
    chk(4'd6, 16'h0001, "R4 interval hi");

    // R7 disabled timer
    wr(4'd6, 16'h0); wr(4'd7, 16'h0);
    chk(4'd9, 16'h0, "R7 count zero");
    ticks(10);
    chk(4'd14, 16'h0, "R7 no fire");
    chk(4'd9, 16'h0, "R7 count held");

    // R6 timer 1 and R10 set wins
    wr(4'd11, 16'd3);
    ticks(3);
    chk(4'd14, 16'h4, "R6 timer1 fire");
    chkIrq(1'b1, "R9 irq timer1");
    chk(4'd13, 16'd3, "R6 timer1 reload");
    ticks(2);
    chk(4'd13, 16'd1, "R6 timer1 count");
    cycle(1'b1, 1'b1, 1'b1, 4'd14, 16'h0004, 1'b0);
    chk(4'd14, 16'h4, "R10 set beats clear");
    wr(4'd14, 16'h0004);
    chk(4'd14, 16'h0, "R9 timer1 cleared");
    chkIrq(1'b0, "R9 irq low");

    cycle(1'b0, 1'b0, 1'b0, 4'd0, 16'd0, 1'b0);
    cycle(1'b0, 1'b0, 1'b0, 4'd0, 16'd0, 1'b0);
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule